// File: doc/BRIEF.md
# Oscillator Fail Flag and Power-Up Control

This block keeps the sticky oscillator-fail flag of a real-time clock and the power-up values of three control bits: the stop bit, the output-level bit and the frequency-test bit. It watches the 32 kHz oscillator signal from a free-running reference clock. It samples the oscillator as data through a synchronizer and detects its rising edges. If no rising edge arrives within a number of reference cycles set at run time, the oscillator counts as stopped.

The fail flag is set when the oscillator stops, while the stop bit is 1, and on a cold power-up. It stays set until the host writes it to 0. That write takes effect only after the oscillator has run without interruption for a qualifying number of oscillator periods (four seconds of a 32768 Hz crystal by default). Every detected stop, and every cycle with the stop bit set, restarts that run count. The stop bit is also sent back to the oscillator as its enable, so writing the stop bit to 1 and then to 0 restarts the oscillator.

The reset input is synchronous. During reset the `cold` input chooses one of two profiles: a first power-up, or a battery-backed power-up that keeps most of the stored state.

Top module: `oscfail_ctrl`

## Requirements
- R1: A reset with `cold`=1 leaves st=1, out_bit=0, ft=0, of_flag=1 and osc_en=0 on the first cycle after reset.
- R2: A reset with `cold`=0 clears ft to 0. It leaves st, out_bit and of_flag at the values they had before the reset.
- R3: A pulse on ctl_we loads ctl_st, ctl_out and ctl_ft into st, out_bit and ft on that clock edge. osc_en is always the inverse of st.
- R4: While st is 1, of_flag is 1 from the next cycle on, and a host write of 0 to the flag has no effect.
- R5: When no oscillator rising edge is seen for stall_limit reference cycles, osc_stopped goes to 1 and of_flag is set. An oscillator that keeps toggling well inside that window never sets the flag.
- R6: Once set, of_flag keeps its value until the host writes it. A write with of_wdata=1 sets the flag at any time.
- R7: A write with of_wdata=0 is ignored until RUN_EDGES oscillator rising edges have been counted since the last stop or stop-bit cycle.
- R8: After that run time has been reached, a write with of_wdata=0 clears of_flag on that clock edge, provided the oscillator is not stopped and st is 0.
- R9: A stop detection resets the run count. After the oscillator resumes, a clear is ignored again until a full RUN_EDGES count has been reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous power-up reset, active low |
| cold | input | 1 | Selects the reset profile: 1 for first power-up, 0 for battery-backed power-up |
| osc_in | input | 1 | Oscillator signal, sampled asynchronously |
| stall_limit | input | LIM_W | Number of reference cycles without an oscillator edge that counts as a stop |
| ctl_we | input | 1 | Write strobe for the three control bits |
| ctl_st | input | 1 | New stop bit value |
| ctl_out | input | 1 | New output-level bit value |
| ctl_ft | input | 1 | New frequency-test bit value |
| of_we | input | 1 | Write strobe for the fail flag |
| of_wdata | input | 1 | Value written to the fail flag |
| st | output | 1 | Stop bit |
| out_bit | output | 1 | Output-level bit |
| ft | output | 1 | Frequency-test bit |
| of_flag | output | 1 | Oscillator-fail flag |
| osc_en | output | 1 | Oscillator enable, the inverse of st |
| osc_stopped | output | 1 | Oscillator counted as stopped |

## Verification
The flag-clear path is tried with three patterns:
- A clear written a few oscillator periods after a restart, which separates a gated clear from an ungated one.
- A clear written after the full run time, which shows that the gate opens.
- A clear written after an oscillator interruption that follows a completed run, which shows that the run count restarts rather than being kept.

Steady toggling against a stopped oscillator checks the stop detector in both directions. The two reset profiles are applied over non-default stored state, so that kept values and cleared values can be told apart.

// File: rtl/oscfail_ctrl.sv
module oscfail_ctrl #(
  parameter int RUN_EDGES = 131072,
  parameter int LIM_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cold,
  input  logic             osc_in,
  input  logic [LIM_W-1:0] stall_limit,
  input  logic             ctl_we,
  input  logic             ctl_st,
  input  logic             ctl_out,
  input  logic             ctl_ft,
  input  logic             of_we,
  input  logic             of_wdata,
  output logic             st,
  output logic             out_bit,
  output logic             ft,
  output logic             of_flag,
  output logic             osc_en,
  output logic             osc_stopped
);
  localparam int RW = $clog2(RUN_EDGES + 1);

  logic [2:0]       osc_sync;
  logic [LIM_W-1:0] idle_cnt;
  logic [RW-1:0]    run_cnt;
  logic             rise, run_ok, of_set;

  assign rise        = osc_sync[1] & ~osc_sync[2];
  assign osc_stopped = idle_cnt >= stall_limit;
  assign run_ok      = run_cnt == RW'(RUN_EDGES);
  assign of_set      = st | osc_stopped;
  assign osc_en      = ~st;

  always_ff @(posedge clk)
    if (!rst_n) osc_sync <= '0;
    else        osc_sync <= {osc_sync[1:0], osc_in};

  always_ff @(posedge clk)
    if (!rst_n)               idle_cnt <= '0;
    else if (rise)            idle_cnt <= '0;
    else if (idle_cnt != '1)  idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n || st || osc_stopped) run_cnt <= '0;
    else if (rise && !run_ok)        run_cnt <= run_cnt + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      ft <= 1'b0;
      if (cold) begin
        st      <= 1'b1;
        out_bit <= 1'b0;
        of_flag <= 1'b1;
      end
    end else begin
      if (ctl_we) begin
        st      <= ctl_st;
        out_bit <= ctl_out;
        ft      <= ctl_ft;
      end
      if (of_set)                          of_flag <= 1'b1;
      else if (of_we && (of_wdata || run_ok)) of_flag <= of_wdata;
    end

  p_st_sets_of_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st |=> of_flag);

  p_stop_sets_of_r5: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stopped |=> of_flag);

  p_early_clear_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (of_flag && !run_ok) |=> of_flag);

  p_clear_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (of_we && !of_wdata && run_ok && !st && !osc_stopped) |=> !of_flag);

  p_stop_restarts_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stopped |=> !run_ok);

  p_write_one_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (of_we && of_wdata) |=> of_flag);
endmodule

// File: tb/oscfail_ctrl_bench.sv
module oscfail_ctrl_bench;
  localparam int RUN = 16;
  localparam int LW  = 8;

  logic clk = 0, rst_n = 0, cold = 1, osc_in = 0;
  logic [LW-1:0] stall_limit = 8'd20;
  logic ctl_we = 0, ctl_st = 0, ctl_out = 0, ctl_ft = 0, of_we = 0, of_wdata = 0;
  logic st, out_bit, ft, of_flag, osc_en, osc_stopped;
  logic xtal_ok = 1;
  int   checks = 0, errors = 0, hcnt = 0;

  always #5 clk = ~clk;

  oscfail_ctrl #(.RUN_EDGES(RUN), .LIM_W(LW)) u_oscfail_ctrl (
    .clk(clk), .rst_n(rst_n), .cold(cold), .osc_in(osc_in), .stall_limit(stall_limit),
    .ctl_we(ctl_we), .ctl_st(ctl_st), .ctl_out(ctl_out), .ctl_ft(ctl_ft),
    .of_we(of_we), .of_wdata(of_wdata), .st(st), .out_bit(out_bit), .ft(ft),
    .of_flag(of_flag), .osc_en(osc_en), .osc_stopped(osc_stopped));

  always @(negedge clk) begin
    if (osc_en && xtal_ok) begin
      hcnt = hcnt + 1;
      if (hcnt == 3) begin osc_in = ~osc_in; hcnt = 0; end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic c);
    @(negedge clk); rst_n = 0; cold = c;
    wait_cyc(4);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic write_ctl(input logic s, input logic o, input logic f);
    ctl_st = s; ctl_out = o; ctl_ft = f; ctl_we = 1;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic write_of(input logic v);
    of_wdata = v; of_we = 1;
    @(negedge clk); of_we = 0;
  endtask

  task automatic t_cold_reset;
    do_reset(1'b1);
    chk("R1 st", st, 1'b1);
    chk("R1 out_bit", out_bit, 1'b0);
    chk("R1 ft", ft, 1'b0);
    chk("R1 of_flag", of_flag, 1'b1);
    chk("R1 osc_en", osc_en, 1'b0);
  endtask

  task automatic t_ctl_write;
    write_ctl(1'b0, 1'b1, 1'b1);
    chk("R3 st", st, 1'b0);
    chk("R3 out_bit", out_bit, 1'b1);
    chk("R3 ft", ft, 1'b1);
    chk("R3 osc_en", osc_en, 1'b1);
  endtask

  task automatic t_early_clear;
    wait_cyc(40);
    write_of(1'b0);
    chk("R7 early clear ignored", of_flag, 1'b1);
  endtask

  task automatic t_late_clear;
    wait_cyc(200);
    write_of(1'b0);
    chk("R8 clear after run time", of_flag, 1'b0);
  endtask

  task automatic t_sticky;
    write_of(1'b1);
    chk("R6 write one sets", of_flag, 1'b1);
    wait_cyc(30);
    chk("R6 flag held", of_flag, 1'b1);
    write_of(1'b0);
    chk("R8 clear again", of_flag, 1'b0);
    wait_cyc(60);
    chk("R5 running osc no stop", osc_stopped, 1'b0);
    chk("R5 running osc keeps flag clear", of_flag, 1'b0);
  endtask

  task automatic t_stall;
    xtal_ok = 0;
    wait_cyc(40);
    chk("R5 stop detected", osc_stopped, 1'b1);
    chk("R5 flag set on stop", of_flag, 1'b1);
    xtal_ok = 1;
    wait_cyc(40);
    chk("R5 stop cleared on resume", osc_stopped, 1'b0);
    write_of(1'b0);
    chk("R9 clear ignored after restart", of_flag, 1'b1);
    wait_cyc(200);
    write_of(1'b0);
    chk("R9 clear after full run", of_flag, 1'b0);
  endtask

  task automatic t_warm_reset_a;
    do_reset(1'b0);
    chk("R2 st kept", st, 1'b0);
    chk("R2 out_bit kept", out_bit, 1'b1);
    chk("R2 ft cleared", ft, 1'b0);
    chk("R2 of_flag kept", of_flag, 1'b0);
  endtask

  task automatic t_stop_bit;
    write_ctl(1'b1, 1'b0, 1'b1);
    chk("R3 st written", st, 1'b1);
    chk("R3 osc_en off", osc_en, 1'b0);
    @(negedge clk);
    chk("R4 flag set by st", of_flag, 1'b1);
    wait_cyc(300);
    write_of(1'b0);
    chk("R4 clear ignored while st", of_flag, 1'b1);
  endtask

  task automatic t_warm_reset_b;
    do_reset(1'b0);
    chk("R2 st kept high", st, 1'b1);
    chk("R2 out_bit kept low", out_bit, 1'b0);
    chk("R2 ft cleared again", ft, 1'b0);
    chk("R2 of_flag kept high", of_flag, 1'b1);
  endtask

  task automatic t_restart;
    write_ctl(1'b0, 1'b0, 1'b0);
    wait_cyc(20);
    write_of(1'b0);
    chk("R7 clear ignored soon after restart", of_flag, 1'b1);
    wait_cyc(200);
    write_of(1'b0);
    chk("R8 clear after restart run", of_flag, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_cold_reset();
    t_ctl_write();
    t_early_clear();
    t_late_clear();
    t_sticky();
    t_stall();
    t_warm_reset_a();
    t_stop_bit();
    t_warm_reset_b();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule